// File: doc/BRIEF.md
# External Bus Cycle Controller

This block converts internal read and write requests on a 24-bit address into timed cycles on an external bus. The upper eight address bits name one of 256 segments of 64 KByte each. Each request is matched against a set of programmable windows, and a default range catches everything else. Every window has a start segment, a size in segments, a bus-active bit and a 2-bit bus type. The bus type picks the data width (8 or 16 bits) and decides whether address and data share one port or use separate ports.

The requester gets back either a single ready pulse with read data, or an illegal-bus trap pulse when the matching configuration has no active bus. The trap case produces no external cycle. At reset, a boot pin chooses between two starting states. In the first, the default range is switched off for single-chip operation. In the second, the default range is active with a bus type sampled from pins. Software rewrites any configuration through a simple write port.

Top module: `ebus_ctrl`

## Requirements
- R1: The bus type code decodes as follows: bit 1 set means a 16-bit data bus and clear means an 8-bit bus; bit 0 set means a multiplexed address phase and clear means a demultiplexed one (00 = 8-bit demux, 01 = 8-bit mux, 10 = 16-bit demux, 11 = 16-bit mux).
- R2: In a multiplexed cycle, `ale` is high for exactly one clock while `ad_out` carries the 16-bit in-segment address with `ad_oe` high. The read strobe `rd_n` or the write strobe `wr_n` goes low in the following clock and stays low for WAIT_CYC clocks. Only one strobe is ever low.
- R3: In a demultiplexed cycle, `ale` stays low and `addr_out` holds the in-segment address unchanged through the whole strobe.
- R4: A request hits a window when that window is active and its segment lies in [start, start+size). If several windows hit, the lowest-numbered one is used. If none hits, the default range is used.
- R5: `cs_n[i]` is low for exactly the address and strobe clocks of a cycle that hit window i. Default-range cycles assert no chip select, and at most one chip select is low at any time.
- R6: A request whose selected configuration has its bus-active bit clear pulses `req_trap` for one clock, in the clock after acceptance. It produces no strobe, no chip select and no ready.
- R7: On reset with `boot_internal` high, every configuration is cleared, so every request traps. On reset with `boot_internal` low, the default range is active and uses `boot_type` as its bus type, while all windows are cleared.
- R8: A configuration write with `cfg_sel` = 0 updates the default range, and `cfg_sel` = i+1 updates window i. The new setting applies to the next accepted request.
- R9: A 16-bit access on an 8-bit bus runs two byte cycles. The first is the low byte at the even address and the second is the high byte at the odd address. One ready pulse follows, and read data is returned as {second byte, first byte}. A 16-bit access always ignores address bit 0.
- R10: With `seg_en` low, the segment used for decoding is forced to 0 and `seg_out` stays 0. With `seg_en` high, `seg_out` carries address bits 23:16 during the cycle.
- R11: `busy` rises in the clock after acceptance. `req_ready` is high for one clock, starting 1 + n·(1+WAIT_CYC) clocks after the accepting edge, where n is the number of byte cycles.
- R12: A byte access on a 16-bit bus uses the lane given by address bit 0 (0 = bits 7:0, 1 = bits 15:8). Write data is driven on both lanes, and read data is returned in `req_rdata[7:0]` with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_internal | input | 1 | Sampled at reset: high selects single-chip start |
| boot_type | input | 2 | Default bus type loaded at reset when boot_internal is low |
| seg_en | input | 1 | Segmentation enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0 = default range, i+1 = window i |
| cfg_act | input | 1 | Bus-active bit to write |
| cfg_type | input | 2 | Bus type code to write |
| cfg_base | input | 8 | Window start segment |
| cfg_size | input | 8 | Window size in segments |
| req_valid | input | 1 | Request strobe, only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_trap | output | 1 | One-clock illegal-bus trap pulse |
| req_rdata | output | 16 | Read data, valid with req_ready |
| busy | output | 1 | Cycle or trap in progress |
| ad_in | input | 16 | Data read from the shared port |
| ad_out | output | 16 | Shared address/data port output |
| ad_oe | output | 1 | Output enable for ad_out |
| addr_out | output | 16 | Separate address port (demultiplexed modes) |
| seg_out | output | 8 | Upper address lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | 4 | Active-low window chip selects |

## Verification
The assertions rely on the requester raising `req_valid` only while `busy` is low. They also rely on `seg_en` and the configuration staying unchanged between acceptance and the ready or trap pulse. The bench issues each request from its idle state and waits for ready or trap before doing anything else. It changes `seg_en` and writes configuration only between requests. Window layouts in the bench keep 16-bit accesses inside a segment, so address plus one never crosses a segment boundary.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int ADDR_W = 24;
    localparam int SEG_W  = 8;
    localparam int OFF_W  = 16;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BT_B8_DEMUX  = 2'b00,
        BT_B8_MUX    = 2'b01,
        BT_B16_DEMUX = 2'b10,
        BT_B16_MUX   = 2'b11
    } btype_e;

    typedef struct packed {
        logic             act;
        btype_e           btype;
        logic [SEG_W-1:0] base;
        logic [SEG_W-1:0] size;
    } bcfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_STRB,
        S_DONE,
        S_TRAP
    } st_e;

    function automatic logic bt_mux(input btype_e b);
        return b[0];
    endfunction

    function automatic logic bt_wide(input btype_e b);
        return b[1];
    endfunction

    // segment lies in [base, base+size) of an active window
    function automatic logic seg_hit(input bcfg_t c, input logic [SEG_W-1:0] seg);
        logic [SEG_W:0] lim;
        lim = {1'b0, c.base} + {1'b0, c.size};
        return c.act && (seg >= c.base) && ({1'b0, seg} < lim);
    endfunction

endpackage

// File: rtl/ebus_cfg.sv
module ebus_cfg
    import ebus_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_internal,
    input  logic [1:0]        boot_type,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  bcfg_t             cfg_wdata,
    output logic              dflt_act,
    output btype_e            dflt_type,
    output bcfg_t [NWIN-1:0]  win
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt_act  <= !boot_internal;
            dflt_type <= boot_internal ? BT_B8_DEMUX : btype_e'(boot_type);
        end else if (cfg_we && cfg_sel == '0) begin
            dflt_act  <= cfg_wdata.act;
            dflt_type <= cfg_wdata.btype;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NWIN; i++) begin
                if (cfg_sel == SEL_W'(i + 1)) win[i] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/ebus_decode.sv
module ebus_decode
    import ebus_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic              dflt_act,
    input  btype_e            dflt_type,
    input  bcfg_t [NWIN-1:0]  win,
    output logic [NWIN-1:0]   cs_sel,
    output btype_e            btype,
    output logic              trap
);

    logic [NWIN-1:0] hit;

    for (genvar i = 0; i < NWIN; i++) begin : g_hit
        assign hit[i] = seg_hit(win[i], seg);
    end

    // walk downward so the lowest-numbered hit is assigned last
    always_comb begin
        cs_sel = '0;
        btype  = dflt_type;
        trap   = !dflt_act;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                cs_sel    = '0;
                cs_sel[i] = 1'b1;
                btype     = win[i].btype;
                trap      = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int WAIT_CYC = 2,
    parameter int CNT_W    = $clog2(WAIT_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_wide,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [NWIN-1:0]    rt_cs,
    input  btype_e             rt_type,
    input  logic               rt_trap,
    input  logic [DATA_W-1:0]  ad_in,
    output logic [DATA_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic [OFF_W-1:0]   addr_out,
    output logic [SEG_W-1:0]   seg_out,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic [NWIN-1:0]    cs_n,
    output logic               ready,
    output logic               trap,
    output logic               busy,
    output logic [DATA_W-1:0]  rdata
);

    st_e                st;
    logic [NWIN-1:0]    cs_q;
    btype_e             bt_q;
    logic               wr_q;
    logic               wide_q;
    logic               second;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wd_q;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  rd_q;

    logic               bus16;
    logic               mux;
    logic               split;
    logic               last;
    logic               active;
    logic [ADDR_W-1:0]  a_cur;
    logic [DATA_W-1:0]  wlane;
    logic [DATA_W-1:0]  rd_next;

    assign bus16  = bt_wide(bt_q);
    assign mux    = bt_mux(bt_q);
    assign split  = wide_q && !bus16;
    assign last   = (cnt == CNT_W'(WAIT_CYC - 1));
    assign active = (st == S_ADDR) || (st == S_STRB);
    assign a_cur  = wide_q ? {addr_q[ADDR_W-1:1], second} : addr_q;

    // write data placed on the lanes
    always_comb begin
        if (bus16) begin
            wlane = wide_q ? wd_q : {wd_q[BYTE_W-1:0], wd_q[BYTE_W-1:0]};
        end else begin
            wlane = {{BYTE_W{1'b0}}, second ? wd_q[DATA_W-1:BYTE_W] : wd_q[BYTE_W-1:0]};
        end
    end

    // read data assembled from the lanes
    always_comb begin
        rd_next = rd_q;
        if (bus16) begin
            if (wide_q) rd_next = ad_in;
            else        rd_next = {{BYTE_W{1'b0}},
                                   addr_q[0] ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0]};
        end else if (split && second) begin
            rd_next[DATA_W-1:BYTE_W] = ad_in[BYTE_W-1:0];
        end else if (split) begin
            rd_next[BYTE_W-1:0] = ad_in[BYTE_W-1:0];
        end else begin
            rd_next = {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cs_q   <= '0;
            bt_q   <= BT_B8_DEMUX;
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            second <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            cnt    <= '0;
            rd_q   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        cs_q   <= rt_cs;
                        bt_q   <= rt_type;
                        wr_q   <= req_write;
                        wide_q <= req_wide;
                        addr_q <= req_addr;
                        wd_q   <= req_wdata;
                        second <= 1'b0;
                        cnt    <= '0;
                        st     <= rt_trap ? S_TRAP : S_ADDR;
                    end
                end
                S_ADDR: begin
                    cnt <= '0;
                    st  <= S_STRB;
                end
                S_STRB: begin
                    if (last) begin
                        if (!wr_q) rd_q <= rd_next;
                        if (split && !second) begin
                            second <= 1'b1;
                            st     <= S_ADDR;
                        end else begin
                            st <= S_DONE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        ale      = (st == S_ADDR) && mux;
        cs_n     = active ? ~cs_q : '1;
        rd_n     = !((st == S_STRB) && !wr_q);
        wr_n     = !((st == S_STRB) && wr_q);
        seg_out  = active ? a_cur[ADDR_W-1:OFF_W] : '0;
        addr_out = (active && !mux) ? a_cur[OFF_W-1:0] : '0;
        if ((st == S_ADDR) && mux) begin
            ad_out = a_cur[OFF_W-1:0];
            ad_oe  = 1'b1;
        end else if (active && wr_q) begin
            ad_out = wlane;
            ad_oe  = 1'b1;
        end else begin
            ad_out = '0;
            ad_oe  = 1'b0;
        end
        ready = (st == S_DONE);
        trap  = (st == S_TRAP);
        busy  = (st != S_IDLE);
        rdata = rd_q;
    end

endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
    import ebus_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int WAIT_CYC = 2,
    parameter int SEL_W    = $clog2(NWIN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_internal,
    input  logic [1:0]         boot_type,
    input  logic               seg_en,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_act,
    input  logic [1:0]         cfg_type,
    input  logic [SEG_W-1:0]   cfg_base,
    input  logic [SEG_W-1:0]   cfg_size,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_wide,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               req_trap,
    output logic [DATA_W-1:0]  req_rdata,
    output logic               busy,
    input  logic [DATA_W-1:0]  ad_in,
    output logic [DATA_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic [OFF_W-1:0]   addr_out,
    output logic [SEG_W-1:0]   seg_out,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic [NWIN-1:0]    cs_n
);

    bcfg_t              cfg_wdata;
    logic               dflt_act;
    btype_e             dflt_type;
    bcfg_t [NWIN-1:0]   win;
    logic [ADDR_W-1:0]  eff_addr;
    logic [NWIN-1:0]    rt_cs;
    btype_e             rt_type;
    logic               rt_trap;

    assign cfg_wdata = '{act: cfg_act, btype: btype_e'(cfg_type), base: cfg_base, size: cfg_size};
    assign eff_addr  = {seg_en ? req_addr[ADDR_W-1:OFF_W] : {SEG_W{1'b0}}, req_addr[OFF_W-1:0]};

    ebus_cfg #(.NWIN(NWIN), .SEL_W(SEL_W)) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .boot_internal (boot_internal),
        .boot_type     (boot_type),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .dflt_act      (dflt_act),
        .dflt_type     (dflt_type),
        .win           (win)
    );

    ebus_decode #(.NWIN(NWIN)) u_dec (
        .seg       (eff_addr[ADDR_W-1:OFF_W]),
        .dflt_act  (dflt_act),
        .dflt_type (dflt_type),
        .win       (win),
        .cs_sel    (rt_cs),
        .btype     (rt_type),
        .trap      (rt_trap)
    );

    ebus_seq #(.NWIN(NWIN), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (eff_addr),
        .req_wdata (req_wdata),
        .rt_cs     (rt_cs),
        .rt_type   (rt_type),
        .rt_trap   (rt_trap),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .addr_out  (addr_out),
        .seg_out   (seg_out),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cs_n      (cs_n),
        .ready     (req_ready),
        .trap      (req_trap),
        .busy      (busy),
        .rdata     (req_rdata)
    );

endmodule

// File: rtl/ebus_chk.sv
module ebus_chk #(
    parameter int NWIN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            seg_en,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_trap,
    input logic            busy,
    input logic            ad_oe,
    input logic [15:0]     addr_out,
    input logic [7:0]      seg_out,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic [NWIN-1:0] cs_n
);

    // R5: never more than one chip select low
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R2: address latch pulse lasts one clock
    p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R2: address is driven during the latch pulse, strobes idle
    p_ale_drive_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && rd_n && wr_n));

    // R2: a strobe follows the latch pulse
    p_ale_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!rd_n || !wr_n));

    // R2: read and write strobes exclusive
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R3: separate address port steady across a strobe
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((!rd_n && $past(!rd_n)) || (!wr_n && $past(!wr_n))) |-> $stable(addr_out));

    // R6: trap produces no bus activity
    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        req_trap |-> (rd_n && wr_n && !ale && !req_ready && (&cs_n)));

    // R6: trap is a single clock
    p_trap_end_r6: assert property (@(posedge clk) disable iff (rst)
        req_trap |=> !busy);

    // R11: ready is a single clock
    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R11: requests only arrive while idle (input assumption)
    p_req_idle_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !busy);

    // R10: no upper address lines without segmentation
    p_seg_off_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !seg_en) |=> (seg_out == '0));

endmodule

bind ebus_ctrl ebus_chk #(.NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg_en    (seg_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_trap  (req_trap),
    .busy      (busy),
    .ad_oe     (ad_oe),
    .addr_out  (addr_out),
    .seg_out   (seg_out),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .cs_n      (cs_n)
);

// File: tb/sim_ebus_ctrl.sv
`timescale 1ns/1ps
module sim_ebus_ctrl;

    localparam int WAIT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_internal = 1'b0;
    logic [1:0]  boot_type = 2'b10;
    logic        seg_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_act = 1'b0;
    logic [1:0]  cfg_type = '0;
    logic [7:0]  cfg_base = '0;
    logic [7:0]  cfg_size = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        req_trap;
    logic [15:0] req_rdata;
    logic        busy;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] addr_out;
    logic [7:0]  seg_out;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [3:0]  cs_n;

    int total = 0;
    int bad   = 0;

    logic        tb_bus16 = 1'b0;
    logic        tb_mux   = 1'b0;
    logic [15:0] lat = '0;
    logic [15:0] cur;

    always #4 clk = ~clk;

    ebus_ctrl #(.NWIN(4), .WAIT_CYC(WAIT)) u0 (
        .clk(clk), .rst(rst), .boot_internal(boot_internal), .boot_type(boot_type),
        .seg_en(seg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_act(cfg_act),
        .cfg_type(cfg_type), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_trap(req_trap), .req_rdata(req_rdata), .busy(busy), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_out(addr_out), .seg_out(seg_out),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    // external memory model: byte value derived from its address
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) if (ale) lat <= ad_out;
    assign cur   = tb_mux ? lat : addr_out;
    assign ad_in = tb_bus16 ? {pat(cur | 16'h1), pat(cur & ~16'h1)} : {8'h00, pat(cur)};

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [23:0] addr;
        logic [15:0] wd;
        logic [2:0]  esel;
        logic [1:0]  etype;
        logic        etrap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 24'h101234, 16'h0000, 3'd1, 2'b01, 1'b0},
        '{1'b0, 1'b1, 24'h110040, 16'h0000, 3'd1, 2'b01, 1'b0},
        '{1'b1, 1'b1, 24'h120100, 16'hBEEF, 3'd2, 2'b11, 1'b0},
        '{1'b0, 1'b1, 24'h140002, 16'h0000, 3'd2, 2'b11, 1'b0},
        '{1'b0, 1'b0, 24'h130005, 16'h0000, 3'd2, 2'b11, 1'b0},
        '{1'b1, 1'b1, 24'h300010, 16'h1234, 3'd4, 2'b00, 1'b0},
        '{1'b0, 1'b0, 24'h30FFFF, 16'h0000, 3'd4, 2'b00, 1'b0},
        '{1'b0, 1'b1, 24'h200008, 16'h0000, 3'd0, 2'b10, 1'b0},
        '{1'b1, 1'b0, 24'h050003, 16'h00A5, 3'd0, 2'b10, 1'b0},
        '{1'b0, 1'b1, 24'h150000, 16'h0000, 3'd0, 2'b10, 1'b0}
    };

    task automatic do_reset(input logic bi, input logic [1:0] bt);
        @(negedge clk);
        rst = 1'b1;
        boot_internal = bi;
        boot_type = bt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_check(input string req);
        chk_eq(req, {ad_oe, ale, rd_n, wr_n, cs_n, req_ready, req_trap, busy},
                    {1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic wcfg(input logic [2:0] sel, input logic act, input logic [1:0] t,
                        input logic [7:0] base, input logic [7:0] size);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_act = act; cfg_type = t;
        cfg_base = base; cfg_size = size;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic wr, input logic wide, input logic [23:0] a,
                          input logic [15:0] wd, input logic [2:0] esel,
                          input logic [1:0] etype, input logic etrap);
        int          ale_cnt = 0;
        int          nstb = 0;
        int          done_k = 0;
        int          cs_bad = 0;
        int          ncyc;
        int          exp_done;
        logic        prev_stb = 1'b0;
        logic        stb;
        logic        got_ready = 1'b0;
        logic        got_trap = 1'b0;
        logic [15:0] sa [2];
        logic [15:0] sd [2];
        logic [7:0]  sseg = '0;
        logic [3:0]  ecs;
        logic [15:0] a0;
        logic [15:0] erd;
        ecs = (esel == 3'd0) ? 4'hF : ~(4'b0001 << (esel - 3'd1));
        ncyc = etrap ? 0 : ((wide && !etype[1]) ? 2 : 1);
        exp_done = etrap ? 1 : 1 + ncyc * (1 + WAIT);
        a0 = wide ? {a[15:1], 1'b0} : a[15:0];
        sa[0] = '0; sa[1] = '0; sd[0] = '0; sd[1] = '0;
        tb_bus16 = etype[1];
        tb_mux   = etype[0];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (ale) ale_cnt++;
            stb = !rd_n || !wr_n;
            if (stb && (cs_n !== ecs)) cs_bad++;
            if (stb && (wr ? rd_n == 1'b0 : wr_n == 1'b0)) cs_bad++;
            if (stb && !prev_stb) begin
                if (nstb < 2) begin
                    sa[nstb] = etype[0] ? lat : addr_out;
                    sd[nstb] = ad_out;
                end
                sseg = seg_out;
                nstb++;
            end
            prev_stb = stb;
            if (req_ready || req_trap) begin
                done_k = k;
                got_ready = req_ready;
                got_trap = req_trap;
                break;
            end
        end
        if (etrap) begin
            chk_eq("R6 trap pulse, no strobe", {got_trap, got_ready, 8'(done_k), 8'(nstb)},
                                               {1'b1, 1'b0, 8'd1, 8'd0});
        end else begin
            chk_eq("R11 ready timing", {got_ready, got_trap, 8'(done_k)},
                                       {1'b1, 1'b0, 8'(exp_done)});
            chk_eq("R1 R9 byte cycle count", nstb, ncyc);
            chk_eq("R2 ale pulses", ale_cnt, etype[0] ? ncyc : 0);
            chk_eq("R4 R5 chip select and strobe", cs_bad, 0);
            chk_eq(etype[0] ? "R2 latched address" : "R3 address port", sa[0], a0);
            if (ncyc == 2) chk_eq("R9 second byte address", sa[1], a0 | 16'h1);
            chk_eq("R10 upper address", sseg, seg_en ? a[23:16] : 8'h00);
            if (!wr) begin
                erd = wide ? {pat(a0 | 16'h1), pat(a0)} : {8'h00, pat(a[15:0])};
                chk_eq((etype[1] && !wide) ? "R12 byte lane read" :
                       (ncyc == 2) ? "R9 split read" : "R1 read data", req_rdata, erd);
            end else if (!etype[1]) begin
                chk_eq("R1 R9 byte write data", sd[0][7:0], wd[7:0]);
                if (ncyc == 2) chk_eq("R9 high byte write", sd[1][7:0], wd[15:8]);
            end else if (wide) begin
                chk_eq("R1 word write data", sd[0], wd);
            end else begin
                chk_eq("R12 byte lane write", a[0] ? sd[0][15:8] : sd[0][7:0], wd[7:0]);
            end
        end
        @(negedge clk);
        idle_check("R11 back to idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7: boot with external start, default 16-bit demux
        do_reset(1'b0, 2'b10);
        idle_check("R7 reset outputs");

        // R8: program windows (0 at 0x10+2, 1 at 0x11+4 overlapping, 2 inactive, 3 at 0x30)
        wcfg(3'd1, 1'b1, 2'b01, 8'h10, 8'd2);
        wcfg(3'd2, 1'b1, 2'b11, 8'h11, 8'd4);
        wcfg(3'd3, 1'b0, 2'b00, 8'h20, 8'd1);
        wcfg(3'd4, 1'b1, 2'b00, 8'h30, 8'd1);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].wr, VEC[i].wide, VEC[i].addr, VEC[i].wd,
                   VEC[i].esel, VEC[i].etype, VEC[i].etrap);
        end

        // R6 R8: default range switched off -> trap
        wcfg(3'd0, 1'b0, 2'b10, 8'h00, 8'h00);
        do_req(1'b0, 1'b1, 24'h050000, 16'h0, 3'd0, 2'b10, 1'b1);

        // R8: default rewritten to 16-bit mux
        wcfg(3'd0, 1'b1, 2'b11, 8'h00, 8'h00);
        do_req(1'b0, 1'b1, 24'h060000, 16'h0, 3'd0, 2'b11, 1'b0);

        // R10: segmentation off, segment 0x10 decodes as 0 -> default range
        seg_en = 1'b0;
        do_req(1'b0, 1'b1, 24'h100020, 16'h0, 3'd0, 2'b11, 1'b0);
        seg_en = 1'b1;

        // R7: single-chip start, everything traps
        do_reset(1'b1, 2'b11);
        idle_check("R7 single-chip reset outputs");
        do_req(1'b0, 1'b0, 24'h000000, 16'h0, 3'd0, 2'b00, 1'b1);

        // R7: external start with 8-bit mux default
        do_reset(1'b0, 2'b01);
        do_req(1'b0, 1'b1, 24'h000010, 16'h0, 3'd0, 2'b01, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule